// File: doc/BRIEF.md
# Synchronous Dual-Port Burst RAM

This block is a two-port memory in which a left port and a right port, each running from its own clock, can read or write any word at any time, including the same word. Each port captures its address, write data and control inputs on the rising edge of its clock. A port addresses the array through its own burst counter. The counter can be cleared, loaded from the address input or advanced by one each cycle, so a burst needs only one address followed by a stream of data beats.

The data word has two byte lanes, and each lane has its own enable for both writes and reads. Each port is selected by a pair of chip selects of opposite polarity, which lets several of these blocks be stacked in depth without decode logic. A static mode input on each port chooses flow-through read timing (data one cycle after the address edge) or pipelined timing (one cycle later, from an output register). The pad tristate is left to the chip level. The block provides the read data together with a per-lane drive-enable, and the asynchronous active-low output enable gates only that drive-enable. Setting `AW` to 16 gives 65536 words. `DW` may be 18 (9-bit lanes) or 16 (8-bit lanes).

Top module: `dp_burst_ram`

## Requirements
- R1: When `clr_n_x` is low at a rising edge, the port's counter becomes 0, whatever `ld_n_x`, `inc_n_x` and `addr_x` are.
- R2: When `clr_n_x` is high and `ld_n_x` is low at an edge, the counter takes `addr_x`, even if `inc_n_x` is also low.
- R3: When only `inc_n_x` is low, the counter advances by one and wraps from 2^AW-1 to 0. When all three counter controls are high, the counter holds.
- R4: A selected port with `rw_x` low (1 = read, 0 = write) writes the registered `din_x` into the word at the counter value from that edge. Successive beats of a burst land in consecutive words.
- R5: `lane_n_x[0]` (active low) enables bits LW-1:0 and `lane_n_x[1]` enables bits DW-1:LW, where LW = DW/2. A write changes only the enabled lanes. A read sets `drv_x` only for enabled lanes, and `dout_x` is zero in every lane that is not driven.
- R6: A port is selected only when `sel_n_x` is 0 and `sel_x` is 1. An unselected port neither writes nor drives (`drv_x` = 0).
- R7: With `pipe_x` = 0, read data and its drive-enable are valid in the cycle that follows the edge registering the read.
- R8: With `pipe_x` = 1, read data appears one cycle later than in R7, and in the cycle R7 would use, `drv_x` is still 0.
- R9: `oe_n_x` high forces `drv_x` and `dout_x` to zero at once, without a clock. Lowering it restores the pending read data.
- R10: Each port reads what the other port wrote. When one port writes a word and the other port reads that word in the same cycle, the read returns the old contents.
- R11: While `rst_n` is low, both counters are zero and neither port drives. After release, a port that reads without loading reads word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of counters and read pipeline |
| clk_l | input | 1 | Left port clock |
| sel_n_l | input | 1 | Left active-low select |
| sel_l | input | 1 | Left active-high select |
| rw_l | input | 1 | Left operation, 1 read, 0 write |
| lane_n_l | input | 2 | Left active-low lane enables, bit 0 lower lane |
| oe_n_l | input | 1 | Left asynchronous active-low output enable |
| pipe_l | input | 1 | Left read timing, 1 pipelined, 0 flow-through |
| ld_n_l | input | 1 | Left active-low counter load |
| inc_n_l | input | 1 | Left active-low counter increment |
| clr_n_l | input | 1 | Left active-low counter clear |
| addr_l | input | AW | Left address loaded into the counter |
| din_l | input | DW | Left write data |
| dout_l | output | DW | Left read data, zero in lanes not driven |
| drv_l | output | 2 | Left per-lane drive-enable for the pad |
| clk_r | input | 1 | Right port clock |
| sel_n_r | input | 1 | Right active-low select |
| sel_r | input | 1 | Right active-high select |
| rw_r | input | 1 | Right operation, 1 read, 0 write |
| lane_n_r | input | 2 | Right active-low lane enables, bit 0 lower lane |
| oe_n_r | input | 1 | Right asynchronous active-low output enable |
| pipe_r | input | 1 | Right read timing, 1 pipelined, 0 flow-through |
| ld_n_r | input | 1 | Right active-low counter load |
| inc_n_r | input | 1 | Right active-low counter increment |
| clr_n_r | input | 1 | Right active-low counter clear |
| addr_r | input | AW | Right address loaded into the counter |
| din_r | input | DW | Right write data |
| dout_r | output | DW | Right read data, zero in lanes not driven |
| drv_r | output | 2 | Right per-lane drive-enable for the pad |

## Verification
The counter assertions assume that the counter controls and the address meet setup at every edge after reset. They also assume that `pipe_x` is a static strap, so it is held constant through any burst. The stimulus changes inputs only on the falling edge and leaves each mode input fixed for the whole of a read burst. It never has both ports write the same word in the same cycle, because that result is undefined. It reads only words whose contents have been written earlier, so the reference array never has to predict uninitialised storage.

// File: rtl/dp_burst_ram.sv
`timescale 1ns/1ps
module dp_burst_ram #(
  parameter int AW = 8,
  parameter int DW = 18
) (
  input  logic          rst_n,
  input  logic          clk_l,
  input  logic          sel_n_l,
  input  logic          sel_l,
  input  logic          rw_l,
  input  logic [1:0]    lane_n_l,
  input  logic          oe_n_l,
  input  logic          pipe_l,
  input  logic          ld_n_l,
  input  logic          inc_n_l,
  input  logic          clr_n_l,
  input  logic [AW-1:0] addr_l,
  input  logic [DW-1:0] din_l,
  output logic [DW-1:0] dout_l,
  output logic [1:0]    drv_l,
  input  logic          clk_r,
  input  logic          sel_n_r,
  input  logic          sel_r,
  input  logic          rw_r,
  input  logic [1:0]    lane_n_r,
  input  logic          oe_n_r,
  input  logic          pipe_r,
  input  logic          ld_n_r,
  input  logic          inc_n_r,
  input  logic          clr_n_r,
  input  logic [AW-1:0] addr_r,
  input  logic [DW-1:0] din_r,
  output logic [DW-1:0] dout_r,
  output logic [1:0]    drv_r
);
  localparam int DEPTH = 1 << AW;
  localparam int LW    = DW / 2;

  function automatic logic [DW-1:0] lane_mask(input logic [1:0] en);
    return {{(DW-LW){en[1]}}, {LW{en[0]}}};
  endfunction

  // Each port owns one bank; the stored word is the XOR of both banks.
  logic [DW-1:0] bank_l [DEPTH];
  logic [DW-1:0] bank_r [DEPTH];

  // ---------------- left port ----------------
  logic [AW-1:0] cnt_l;
  logic          acc_l, rd_l, live_l;
  logic [1:0]    len_l, pen_l, ften_l, en_l;
  logic [DW-1:0] dq_l, pdat_l, rword_l, wm_l, src_l;

  always_ff @(posedge clk_l or negedge rst_n)
    if (!rst_n) begin
      cnt_l  <= '0;
      acc_l  <= 1'b0;
      rd_l   <= 1'b1;
      len_l  <= '0;
      dq_l   <= '0;
      pen_l  <= '0;
      pdat_l <= '0;
      live_l <= 1'b0;
    end else begin
      live_l <= 1'b1;
      if (!clr_n_l)      cnt_l <= '0;
      else if (!ld_n_l)  cnt_l <= addr_l;
      else if (!inc_n_l) cnt_l <= cnt_l + 1'b1;
      acc_l  <= !sel_n_l && sel_l;
      rd_l   <= rw_l;
      len_l  <= ~lane_n_l;
      dq_l   <= din_l;
      pen_l  <= ften_l;
      pdat_l <= rword_l;
    end

  assign wm_l = lane_mask(len_l);

  always_ff @(posedge clk_l)
    if (acc_l && !rd_l)
      bank_l[cnt_l] <= (bank_l[cnt_l] & ~wm_l) | ((dq_l ^ bank_r[cnt_l]) & wm_l);

  assign rword_l = bank_l[cnt_l] ^ bank_r[cnt_l];
  assign ften_l  = (acc_l && rd_l) ? len_l : 2'b00;
  assign en_l    = (pipe_l ? pen_l : ften_l) & {2{!oe_n_l}};
  assign src_l   = pipe_l ? pdat_l : rword_l;
  assign dout_l  = src_l & lane_mask(en_l);
  assign drv_l   = en_l;

  AST_CLR_L:   assert property (@(posedge clk_l) disable iff (!rst_n)
                 live_l && !$past(clr_n_l) |-> cnt_l == '0);                                   // R1
  AST_LOAD_L:  assert property (@(posedge clk_l) disable iff (!rst_n)
                 live_l && $past(clr_n_l) && !$past(ld_n_l) |-> cnt_l == $past(addr_l));        // R2
  AST_INC_L:   assert property (@(posedge clk_l) disable iff (!rst_n)
                 live_l && $past(clr_n_l && ld_n_l && !inc_n_l) |-> cnt_l == $past(cnt_l) + 1'b1); // R3
  AST_DESEL_L: assert property (@(posedge clk_l) disable iff (!rst_n)
                 live_l && $past(sel_n_l || !sel_l) |-> !acc_l);                                 // R6

  // ---------------- right port ----------------
  logic [AW-1:0] cnt_r;
  logic          acc_r, rd_r, live_r;
  logic [1:0]    len_r, pen_r, ften_r, en_r;
  logic [DW-1:0] dq_r, pdat_r, rword_r, wm_r, src_r;

  always_ff @(posedge clk_r or negedge rst_n)
    if (!rst_n) begin
      cnt_r  <= '0;
      acc_r  <= 1'b0;
      rd_r   <= 1'b1;
      len_r  <= '0;
      dq_r   <= '0;
      pen_r  <= '0;
      pdat_r <= '0;
      live_r <= 1'b0;
    end else begin
      live_r <= 1'b1;
      if (!clr_n_r)      cnt_r <= '0;
      else if (!ld_n_r)  cnt_r <= addr_r;
      else if (!inc_n_r) cnt_r <= cnt_r + 1'b1;
      acc_r  <= !sel_n_r && sel_r;
      rd_r   <= rw_r;
      len_r  <= ~lane_n_r;
      dq_r   <= din_r;
      pen_r  <= ften_r;
      pdat_r <= rword_r;
    end

  assign wm_r = lane_mask(len_r);

  always_ff @(posedge clk_r)
    if (acc_r && !rd_r)
      bank_r[cnt_r] <= (bank_r[cnt_r] & ~wm_r) | ((dq_r ^ bank_l[cnt_r]) & wm_r);

  assign rword_r = bank_l[cnt_r] ^ bank_r[cnt_r];
  assign ften_r  = (acc_r && rd_r) ? len_r : 2'b00;
  assign en_r    = (pipe_r ? pen_r : ften_r) & {2{!oe_n_r}};
  assign src_r   = pipe_r ? pdat_r : rword_r;
  assign dout_r  = src_r & lane_mask(en_r);
  assign drv_r   = en_r;

  AST_CLR_R:   assert property (@(posedge clk_r) disable iff (!rst_n)
                 live_r && !$past(clr_n_r) |-> cnt_r == '0);                                   // R1
  AST_HOLD_R:  assert property (@(posedge clk_r) disable iff (!rst_n)
                 live_r && $past(clr_n_r && ld_n_r && inc_n_r) |-> cnt_r == $past(cnt_r));      // R3
  AST_DESEL_R: assert property (@(posedge clk_r) disable iff (!rst_n)
                 live_r && $past(sel_n_r || !sel_r) |-> !acc_r);                                 // R6
endmodule

// File: tb/dp_burst_ram_bench.sv
`timescale 1ns/1ps
module dp_burst_ram_bench;
  localparam int AW = 4;
  localparam int DW = 18;
  localparam int LW = DW / 2;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] a [2];
  logic [DW-1:0] di [2];
  logic          rw [2], sn [2], s [2], oen [2], pp [2], ldn [2], incn [2], clrn [2];
  logic [1:0]    ln [2];
  wire  [DW-1:0] dq [2];
  wire  [1:0]    dv [2];

  logic [DW-1:0] mref [N];
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dp_burst_ram #(.AW(AW), .DW(DW)) u_dp_burst_ram (
    .rst_n(rst_n),
    .clk_l(clk), .sel_n_l(sn[0]), .sel_l(s[0]), .rw_l(rw[0]), .lane_n_l(ln[0]),
    .oe_n_l(oen[0]), .pipe_l(pp[0]), .ld_n_l(ldn[0]), .inc_n_l(incn[0]), .clr_n_l(clrn[0]),
    .addr_l(a[0]), .din_l(di[0]), .dout_l(dq[0]), .drv_l(dv[0]),
    .clk_r(clk), .sel_n_r(sn[1]), .sel_r(s[1]), .rw_r(rw[1]), .lane_n_r(ln[1]),
    .oe_n_r(oen[1]), .pipe_r(pp[1]), .ld_n_r(ldn[1]), .inc_n_r(incn[1]), .clr_n_r(clrn[1]),
    .addr_r(a[1]), .din_r(di[1]), .dout_r(dq[1]), .drv_r(dv[1])
  );

  function automatic logic [DW-1:0] lm(input logic [1:0] e);
    return {{(DW-LW){e[1]}}, {LW{e[0]}}};
  endfunction

  function automatic logic [DW-1:0] pat(input int seed, input int i);
    return DW'(seed * 40503 + i * 2654435 + 12345);
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int p);
    sn[p] = 1'b1; s[p] = 1'b1; rw[p] = 1'b1; ln[p] = 2'b11;
    ldn[p] = 1'b1; incn[p] = 1'b1; clrn[p] = 1'b1; a[p] = '0; di[p] = '0;
  endtask

  task automatic chk_raw(input int p, input logic [DW-1:0] ed, input logic [1:0] ev, input string req);
    nchk++;
    if (dq[p] !== ed || dv[p] !== ev) begin
      nfail++;
      $display("FAIL %s port%0d: got %h/%b expected %h/%b", req, p, dq[p], dv[p], ed, ev);
    end
  endtask

  task automatic chk(input int p, input int ad, input logic [1:0] lanes_n, input string req);
    logic [1:0] ev;
    ev = oen[p] ? 2'b00 : ~lanes_n;
    chk_raw(p, mref[AW'(ad)] & lm(ev), ev, req);
  endtask

  task automatic burst_wr(input int p, input int start, input int n, input int seed, input logic [1:0] lanes_n);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] ad;
      ad = AW'(start + i);
      sn[p] = 1'b0; s[p] = 1'b1; rw[p] = 1'b0; ln[p] = lanes_n;
      a[p] = AW'(start); di[p] = pat(seed, i);
      ldn[p] = (i == 0) ? 1'b0 : 1'b1;
      incn[p] = (i == 0) ? 1'b1 : 1'b0;
      mref[ad] = (mref[ad] & ~lm(~lanes_n)) | (pat(seed, i) & lm(~lanes_n));
      step();
    end
    idle(p);
    step();
  endtask

  task automatic burst_rd(input int p, input int start, input int n, input logic [1:0] lanes_n, input string req);
    for (int i = 0; i < n; i++) begin
      sn[p] = 1'b0; s[p] = 1'b1; rw[p] = 1'b1; ln[p] = lanes_n; a[p] = AW'(start);
      ldn[p] = (i == 0) ? 1'b0 : 1'b1;
      incn[p] = (i == 0) ? 1'b1 : 1'b0;
      step();
      if (!pp[p]) chk(p, start + i, lanes_n, req);
      else if (i == 0) chk_raw(p, '0, 2'b00, "R8 latency");
      else chk(p, start + i - 1, lanes_n, req);
    end
    idle(p);
    step();
    if (pp[p]) chk(p, start + n - 1, lanes_n, req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired: got running expected finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      idle(p); oen[p] = 1'b0; pp[p] = 1'b0;
    end
    rst_n = 1'b0;
    step(); step();
    chk_raw(0, '0, 2'b00, "R11 reset left");
    chk_raw(1, '0, 2'b00, "R11 reset right");
    rst_n = 1'b1;
    step();

    // Sweep: every writer port, every read mode, every word, with wrap (R3, R4, R7, R8, R10)
    for (int wp = 0; wp < 2; wp++)
      for (int md = 0; md < 2; md++) begin
        int st;
        st = md * 7 + wp * 3 + 5;
        pp[1-wp] = md[0];
        burst_wr(wp, st, N, wp * 2 + md + 1, 2'b00);
        burst_rd(1 - wp, st, N, 2'b00, md ? "R8 R10 R3 pipelined wrap" : "R7 R10 R4 flow wrap");
      end
    pp[0] = 1'b0; pp[1] = 1'b0;

    // R5: lane-masked write then full and upper-only reads
    burst_wr(1, 3, 1, 77, 2'b10);
    burst_rd(0, 3, 1, 2'b00, "R5 lower-lane write");
    burst_wr(1, 3, 2, 91, 2'b01);
    burst_rd(0, 3, 2, 2'b00, "R5 upper-lane write");
    burst_rd(0, 3, 2, 2'b01, "R5 upper-lane read");
    pp[0] = 1'b1;
    burst_rd(0, 4, 1, 2'b10, "R5 lower-lane pipelined read");
    pp[0] = 1'b0;

    // R6: deselected writes leave memory unchanged, deselected reads do not drive
    sn[0] = 1'b1; s[0] = 1'b1; rw[0] = 1'b0; ln[0] = 2'b00; ldn[0] = 1'b0; a[0] = 4'd7; di[0] = ~mref[7];
    step();
    sn[0] = 1'b0; s[0] = 1'b0; a[0] = 4'd8; di[0] = ~mref[8];
    step();
    idle(0); step();
    burst_rd(1, 7, 2, 2'b00, "R6 deselected write ignored");
    sn[1] = 1'b1; rw[1] = 1'b1; ln[1] = 2'b00; ldn[1] = 1'b0; a[1] = 4'd7;
    step();
    chk_raw(1, '0, 2'b00, "R6 deselected read");
    sn[1] = 1'b0; s[1] = 1'b0;
    step();
    chk_raw(1, '0, 2'b00, "R6 deselected read sel low");
    idle(1); step();

    // R9: asynchronous output enable
    sn[1] = 1'b0; s[1] = 1'b1; rw[1] = 1'b1; ln[1] = 2'b00; ldn[1] = 1'b0; a[1] = 4'd4; oen[1] = 1'b1;
    step();
    chk(1, 4, 2'b00, "R9 oe high");
    ldn[1] = 1'b1; oen[1] = 1'b0;
    #1;
    chk(1, 4, 2'b00, "R9 oe low restores");
    @(negedge clk);
    idle(1); step();

    // R1, R2, R3: counter priority, hold and wrap on the left port, flow-through
    sn[0] = 1'b0; s[0] = 1'b1; rw[0] = 1'b1; ln[0] = 2'b00;
    clrn[0] = 1'b0; ldn[0] = 1'b0; incn[0] = 1'b0; a[0] = 4'd9;
    step(); chk(0, 0, 2'b00, "R1 clear beats load");
    clrn[0] = 1'b1; a[0] = 4'd12;
    step(); chk(0, 12, 2'b00, "R2 load beats increment");
    ldn[0] = 1'b1;
    step(); chk(0, 13, 2'b00, "R3 increment");
    incn[0] = 1'b1;
    step(); chk(0, 13, 2'b00, "R3 hold");
    ldn[0] = 1'b0; a[0] = 4'd15;
    step(); chk(0, 15, 2'b00, "R2 load top");
    ldn[0] = 1'b0; ldn[0] = 1'b1; incn[0] = 1'b0;
    step(); chk(0, 0, 2'b00, "R3 wrap to zero");
    idle(0); step();

    // R10: same-cycle write on left and read on right of word 2
    begin
      logic [DW-1:0] nv;
      nv = ~mref[2];
      sn[0] = 1'b0; s[0] = 1'b1; rw[0] = 1'b0; ln[0] = 2'b00; ldn[0] = 1'b0; a[0] = 4'd2; di[0] = nv;
      sn[1] = 1'b0; s[1] = 1'b1; rw[1] = 1'b1; ln[1] = 2'b00; ldn[1] = 1'b0; a[1] = 4'd2;
      step();
      chk(1, 2, 2'b00, "R10 collision old data");
      idle(0); ldn[1] = 1'b1;
      mref[2] = nv;
      step();
      chk(1, 2, 2'b00, "R10 new data after collision");
      idle(1); step();
    end

    // R11: reset returns the counter to zero
    rst_n = 1'b0;
    #1;
    chk_raw(0, '0, 2'b00, "R11 reset clears drive");
    step();
    rst_n = 1'b1;
    step();
    sn[1] = 1'b0; s[1] = 1'b1; rw[1] = 1'b1; ln[1] = 2'b00;
    step();
    chk(1, 0, 2'b00, "R11 counter zero after reset");
    idle(1); step();

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule